// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block watches the command stream that a memory controller sends to a four-bank SDRAM. It keeps, for every bank, a phase (idle, opening, open, closing), the row last opened there, and a set of down-counters. From these it reports, each cycle, which bank may take a row activation, a column access or a precharge. Commands arrive already decoded: a command code, a bank number, the A10 address bit and the row address. Refresh, the mode register and data movement are not part of this block.

A controller or a protocol monitor uses it to decide what it may issue next. Any command that breaks a rule is refused. A refused command leaves every bank as it was, and a one-cycle flag appears in the following cycle. All timing limits are whole clock-cycle counts set by parameters.

Cycle counting: a command is sampled on a rising edge. "j cycles after" a command means the j-th rising edge after the edge that sampled it.

Top module: `sdr_bank_guard`

## Requirements
- R1: After reset every bank is idle (phase code 0), all activation and precharge permissions are high, column permissions are low, and the illegal flag is low. Phase codes are: idle=0, opening=1, open=2, closing=3. Command codes are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. Codes 5 to 7 act as no-ops.
- R2: A legal activate stores `row_i` as that bank's open row and moves the bank out of idle in the next cycle.
- R3: Read and write to a bank become legal T_RCD cycles after its activate, and not earlier.
- R4: A precharge to an open bank becomes legal T_RAS cycles after its activate, and not earlier.
- R5: Two activates, to any banks, are at least T_RRD cycles apart.
- R6: Two activates to the same bank are at least T_RC cycles apart.
- R7: After a read with A10 high (auto-precharge), the next activate to that bank is legal no earlier than BURST_LEN + T_RP cycles after the read.
- R8: After a write with A10 high, the next activate to that bank is legal no earlier than BURST_LEN + T_WR - 1 + T_RP cycles after the write.
- R9: While a bank is auto-precharging, any read, write or precharge to that bank is illegal. Commands to other banks remain legal.
- R10: After a write without auto-precharge, a precharge to that bank is legal no earlier than BURST_LEN - 1 + T_WR cycles after the write.
- R11: A precharge with A10 high is legal only if every bank would accept a precharge. When legal, it starts closing every open bank.
- R12: A single-bank precharge moves an open bank to closing. The bank is idle again, and may be activated, T_RP cycles later (T_RC permitting).
- R13: An illegal command leaves phases and rows unchanged and raises `illegal_o` for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BANK_W (2) | Target bank |
| a10_i | input | 1 | Auto-precharge select (read/write) or all-bank select (precharge) |
| row_i | input | ROW_W (13) | Row address for activate |
| act_ok_o | output | NB (4) | Activate is legal now, per bank |
| rw_ok_o | output | NB (4) | Read/write is legal now, per bank |
| pre_ok_o | output | NB (4) | Single precharge is legal now, per bank |
| bank_state_o | output | 2*NB (8) | Phase code per bank, bank b at bits 2b+1:2b |
| open_row_o | output | ROW_W*NB (52) | Stored row per bank, bank b at bits ROW_W*b upward |
| illegal_o | output | 1 | One-cycle pulse after an illegal command |

## Verification
The bench uses T_RCD=3, T_RAS=6, T_RP=3, T_RC=10, T_RRD=2, T_WR=2 and BURST_LEN=4. These values are chosen so that every limit it measures is set by one rule alone. T_RC exceeds T_RAS+T_RP, so the same-bank activate spacing is not hidden behind the precharge. Each auto-precharge window ends after T_RC has already run out. The write-recovery wait ends after T_RAS. Each measurement counts the cycles from a command until a permission rises, so an off-by-one in any single window shows up as a wrong count.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPENING = 2'd1,
    BK_OPEN    = 2'd2,
    BK_CLOSING = 2'd3
  } bank_st_e;

  // Cycles from a read with auto-precharge to the next legal activate.
  function automatic int rd_ap_span(int bl, int trp);
    return bl + trp;
  endfunction

  // Cycles from a write with auto-precharge to the next legal activate.
  function automatic int wr_ap_span(int bl, int twr, int trp);
    return bl + twr - 1 + trp;
  endfunction

  // Cycles from a plain write to the earliest legal precharge.
  function automatic int wr_rec_span(int bl, int twr);
    return bl - 1 + twr;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Counter width able to hold span-1 (at least one bit).
  function automatic int span_width(int span);
    return (span <= 2) ? 1 : $clog2(span);
  endfunction

endpackage

// File: rtl/bg_span_count.sv
// Loadable down-counter; zero_o high once the loaded span has run out.
module bg_span_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bg_bank_track.sv
// Phase, row and timing windows of one bank.
module bg_bank_track
  import bank_guard_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go_i,
  input  logic             rd_go_i,
  input  logic             wr_go_i,
  input  logic             ap_i,
  input  logic             pre_go_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [1:0]       state_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_ok_o,
  output logic             pre_ok_o,
  output logic             act_ready_o
);
  localparam logic [CNT_W-1:0] RCD_LD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RAS_LD  = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] RDAP_LD = CNT_W'(rd_ap_span(BURST_LEN, T_RP) - 1);
  localparam logic [CNT_W-1:0] WRAP_LD = CNT_W'(wr_ap_span(BURST_LEN, T_WR, T_RP) - 1);
  localparam logic [CNT_W-1:0] WREC_LD = CNT_W'(wr_rec_span(BURST_LEN, T_WR) - 1);

  bank_st_e         state_q;
  logic [CNT_W-1:0] phase_q;
  logic [ROW_W-1:0] row_q;
  logic             close_now;
  logic [CNT_W-1:0] close_ld;
  logic             ras_done, rc_done, wrec_done;

  // Events that start a close: explicit precharge of an open bank, or a column access with auto-precharge.
  assign close_now = (pre_go_i && state_q == BK_OPEN) || ((rd_go_i || wr_go_i) && ap_i);

  always_comb begin
    if (pre_go_i)     close_ld = RP_LD;
    else if (rd_go_i) close_ld = RDAP_LD;
    else              close_ld = WRAP_LD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BK_IDLE;
      phase_q <= '0;
      row_q   <= '0;
    end else if (act_go_i) begin
      row_q   <= row_i;
      phase_q <= RCD_LD;
      state_q <= (RCD_LD == '0) ? BK_OPEN : BK_OPENING;
    end else if (close_now) begin
      phase_q <= close_ld;
      state_q <= (close_ld == '0) ? BK_IDLE : BK_CLOSING;
    end else if (phase_q != '0) begin
      phase_q <= phase_q - 1'b1;
      if (phase_q == CNT_W'(1))
        state_q <= (state_q == BK_OPENING) ? BK_OPEN : BK_IDLE;
    end
  end

  bg_span_count #(.W(CNT_W)) u_ras (
    .clk(clk), .rst_n(rst_n), .load_i(act_go_i), .val_i(RAS_LD), .zero_o(ras_done));

  bg_span_count #(.W(CNT_W)) u_rc (
    .clk(clk), .rst_n(rst_n), .load_i(act_go_i), .val_i(RC_LD), .zero_o(rc_done));

  bg_span_count #(.W(CNT_W)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load_i(wr_go_i && !ap_i), .val_i(WREC_LD), .zero_o(wrec_done));

  assign state_o     = state_q;
  assign row_o       = row_q;
  assign rw_ok_o     = (state_q == BK_OPEN);
  assign pre_ok_o    = (state_q == BK_IDLE) || (state_q == BK_OPEN && ras_done && wrec_done);
  assign act_ready_o = (state_q == BK_IDLE) && rc_done;
endmodule

// File: rtl/bg_cmd_gate.sv
// Judges the incoming command against the permissions and fans out per-bank strobes.
module bg_cmd_gate
  import bank_guard_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              a10_i,
  input  logic [NB-1:0]     act_ok_i,
  input  logic [NB-1:0]     rw_ok_i,
  input  logic [NB-1:0]     pre_ok_i,
  output logic [NB-1:0]     act_go_o,
  output logic [NB-1:0]     rd_go_o,
  output logic [NB-1:0]     wr_go_o,
  output logic [NB-1:0]     pre_go_o,
  output logic              bad_o
);
  logic [NB-1:0] sel;
  logic          legal;
  logic          known;

  always_comb begin
    sel         = '0;
    sel[bank_i] = 1'b1;
    known       = 1'b1;
    legal       = 1'b1;
    case (cmd_i)
      CMD_ACT:         legal = act_ok_i[bank_i];
      CMD_RD, CMD_WR:  legal = rw_ok_i[bank_i];
      CMD_PRE:         legal = a10_i ? (&pre_ok_i) : pre_ok_i[bank_i];
      default:         known = 1'b0;
    endcase
  end

  assign act_go_o = (cmd_i == CMD_ACT && legal) ? sel : '0;
  assign rd_go_o  = (cmd_i == CMD_RD  && legal) ? sel : '0;
  assign wr_go_o  = (cmd_i == CMD_WR  && legal) ? sel : '0;
  assign pre_go_o = (cmd_i == CMD_PRE && legal) ? (a10_i ? '1 : sel) : '0;
  assign bad_o    = known && !legal;
endmodule

// File: rtl/sdr_bank_guard.sv
module sdr_bank_guard
  import bank_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int ROW_W     = 13,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic                a10_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NB-1:0]       act_ok_o,
  output logic [NB-1:0]       rw_ok_o,
  output logic [NB-1:0]       pre_ok_o,
  output logic [2*NB-1:0]     bank_state_o,
  output logic [ROW_W*NB-1:0] open_row_o,
  output logic                illegal_o
);
  localparam int MAX_SPAN = max2(max2(max2(T_RC, T_RAS), max2(T_RRD, T_RCD)),
                                 max2(max2(rd_ap_span(BURST_LEN, T_RP),
                                           wr_ap_span(BURST_LEN, T_WR, T_RP)),
                                      wr_rec_span(BURST_LEN, T_WR)));
  localparam int CNT_W = span_width(MAX_SPAN);
  localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(T_RRD - 1);

  // Named internal events, visible to the bound checker.
  logic [NB-1:0] act_go, rd_go, wr_go, pre_go;
  logic [NB-1:0] act_ready;
  logic          act_any;
  logic          cmd_bad;
  logic          rrd_done;
  logic          illegal_q;

  assign act_any = |act_go;

  bg_cmd_gate #(.NB(NB), .BANK_W(BANK_W)) u_gate (
    .cmd_i    (cmd_i),
    .bank_i   (bank_i),
    .a10_i    (a10_i),
    .act_ok_i (act_ok_o),
    .rw_ok_i  (rw_ok_o),
    .pre_ok_i (pre_ok_o),
    .act_go_o (act_go),
    .rd_go_o  (rd_go),
    .wr_go_o  (wr_go),
    .pre_go_o (pre_go),
    .bad_o    (cmd_bad)
  );

  // Cross-bank activate spacing.
  bg_span_count #(.W(CNT_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load_i(act_any), .val_i(RRD_LD), .zero_o(rrd_done));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bg_bank_track #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .T_RC(T_RC), .T_WR(T_WR), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_go_i    (act_go[b]),
      .rd_go_i     (rd_go[b]),
      .wr_go_i     (wr_go[b]),
      .ap_i        (a10_i),
      .pre_go_i    (pre_go[b]),
      .row_i       (row_i),
      .state_o     (bank_state_o[2*b +: 2]),
      .row_o       (open_row_o[ROW_W*b +: ROW_W]),
      .rw_ok_o     (rw_ok_o[b]),
      .pre_ok_o    (pre_ok_o[b]),
      .act_ready_o (act_ready[b])
    );
  end

  assign act_ok_o = act_ready & {NB{rrd_done}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= cmd_bad;
  end

  assign illegal_o = illegal_q;
endmodule

// File: rtl/bg_guard_checker.sv
module bg_guard_checker
  import bank_guard_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ROW_W  = 13,
  parameter int T_RRD  = 2,
  parameter int BANK_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cmd_i,
  input logic [BANK_W-1:0]   bank_i,
  input logic                a10_i,
  input logic [ROW_W-1:0]    row_i,
  input logic [NB-1:0]       act_ok_o,
  input logic [NB-1:0]       rw_ok_o,
  input logic [NB-1:0]       pre_ok_o,
  input logic [2*NB-1:0]     bank_state_o,
  input logic [ROW_W*NB-1:0] open_row_o,
  input logic                illegal_o
);
  // R5: no activate anywhere in the cycle after a legal activate.
  p_rrd_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && cmd_i == CMD_ACT && act_ok_o[bank_i]) |=> (act_ok_o == '0));

  for (genvar b = 0; b < NB; b++) begin : g_chk
    // R6: activate permission only for an idle bank.
    p_act_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      act_ok_o[b] |-> (bank_state_o[2*b +: 2] == BK_IDLE));

    // R3: column permission only for a fully open bank.
    p_rw_needs_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rw_ok_o[b] |-> (bank_state_o[2*b +: 2] == BK_OPEN));

    // R2: legal activate captures the row and leaves idle.
    p_row_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACT && bank_i == BANK_W'(b) && act_ok_o[b]) |=>
        (open_row_o[ROW_W*b +: ROW_W] == $past(row_i)) &&
        (bank_state_o[2*b +: 2] != BK_IDLE));

    // R13: refused activate flags and keeps the stored row.
    p_bad_act_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACT && bank_i == BANK_W'(b) && !act_ok_o[b]) |=>
        illegal_o && $stable(open_row_o[ROW_W*b +: ROW_W]));

    // R12: single precharge of an open bank starts its close.
    p_pre_closes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_PRE && !a10_i && bank_i == BANK_W'(b) && pre_ok_o[b] &&
       bank_state_o[2*b +: 2] == BK_OPEN) |=>
        (bank_state_o[2*b +: 2] == BK_CLOSING || bank_state_o[2*b +: 2] == BK_IDLE));
  end
endmodule

bind sdr_bank_guard bg_guard_checker #(
  .NB(NB), .ROW_W(ROW_W), .T_RRD(T_RRD), .BANK_W(BANK_W)
) u_guard_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_i        (cmd_i),
  .bank_i       (bank_i),
  .a10_i        (a10_i),
  .row_i        (row_i),
  .act_ok_o     (act_ok_o),
  .rw_ok_o      (rw_ok_o),
  .pre_ok_o     (pre_ok_o),
  .bank_state_o (bank_state_o),
  .open_row_o   (open_row_o),
  .illegal_o    (illegal_o)
);

// File: tb/tb_sdr_bank_guard.sv
module tb_sdr_bank_guard;
  localparam int NB = 4, ROW_W = 13;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 10, T_RRD = 2, T_WR = 2, BL = 4;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [1:0] bank = '0;
  logic a10 = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic [NB-1:0] act_ok, rw_ok, pre_ok;
  logic [2*NB-1:0] bstate;
  logic [ROW_W*NB-1:0] orow;
  logic illegal;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdr_bank_guard #(.NB(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR), .BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .a10_i(a10), .row_i(row),
    .act_ok_o(act_ok), .rw_ok_o(rw_ok), .pre_ok_o(pre_ok), .bank_state_o(bstate),
    .open_row_o(orow), .illegal_o(illegal));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int st(input int b);
    return int'(bstate[2*b +: 2]);
  endfunction

  function automatic int rowof(input int b);
    return int'(orow[ROW_W*b +: ROW_W]);
  endfunction

  // Drive one command at a falling edge; returns at the next falling edge.
  task automatic step(input logic [2:0] c, input int b, input logic a, input int r);
    cmd = c; bank = 2'(b); a10 = a; row = ROW_W'(r);
    @(negedge clk);
  endtask

  task automatic nop();
    step(NOP, 0, 1'b0, 0);
  endtask

  task automatic do_reset();
    cmd = NOP; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // which: 0 activate ok, 1 column ok, 2 precharge ok, 3 idle. j is the edge index after the last command.
  function automatic bit okv(input int which, input int b);
    case (which)
      0: return act_ok[b];
      1: return rw_ok[b];
      2: return pre_ok[b];
      default: return st(b) == 0;
    endcase
  endfunction

  task automatic wait_ok(input int which, input int b, output int j);
    j = 1;
    while (!okv(which, b) && j < 64) begin
      nop();
      j++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 act_ok after reset", int'(act_ok), 15);
    chk("R1 pre_ok after reset", int'(pre_ok), 15);
    chk("R1 rw_ok after reset", int'(rw_ok), 0);
    chk("R1 phases after reset", int'(bstate), 0);
    chk("R1 illegal after reset", int'(illegal), 0);
  endtask

  task automatic t_act_row();
    int j;
    do_reset();
    step(ACT, 2, 1'b0, 'h1ABC);
    chk("R2 phase after activate", st(2), 1);
    chk("R2 stored row", rowof(2), 'h1ABC);
    wait_ok(1, 2, j);
    chk("R3 activate-to-column cycles", j, T_RCD);
    do_reset();
    step(ACT, 1, 1'b0, 7);
    wait_ok(2, 1, j);
    chk("R4 activate-to-precharge cycles", j, T_RAS);
  endtask

  task automatic t_rrd();
    int j;
    do_reset();
    step(ACT, 0, 1'b0, 1);
    chk("R6 same bank refused at once", int'(act_ok[0]), 0);
    wait_ok(0, 1, j);
    chk("R5 cross-bank activate spacing", j, T_RRD);
  endtask

  task automatic t_rc();
    int j1, j2;
    do_reset();
    step(ACT, 0, 1'b0, 3);
    wait_ok(2, 0, j1);
    step(PRE, 0, 1'b0, 0);
    wait_ok(0, 0, j2);
    chk("R6 same-bank activate spacing", j1 + j2, T_RC);
  endtask

  task automatic t_read_ap();
    int j;
    do_reset();
    step(ACT, 0, 1'b0, 10);
    wait_ok(0, 1, j);
    step(ACT, 1, 1'b0, 11);
    wait_ok(1, 0, j);
    nop();
    step(RD, 0, 1'b1, 0);
    chk("R9 bank closing during auto-precharge", st(0), 3);
    chk("R9 precharge refused in window", int'(pre_ok[0]), 0);
    step(RD, 0, 1'b0, 0);
    chk("R9 same-bank read flagged", int'(illegal), 1);
    step(RD, 1, 1'b0, 0);
    chk("R9 other-bank read accepted", int'(illegal), 0);
    wait_ok(0, 0, j);
    chk("R7 read auto-precharge to activate", 2 + j, BL + T_RP);
  endtask

  task automatic t_write_ap();
    int j;
    do_reset();
    step(ACT, 2, 1'b0, 20);
    wait_ok(1, 2, j);
    step(WR, 2, 1'b1, 0);
    wait_ok(0, 2, j);
    chk("R8 write auto-precharge to activate", j, BL + T_WR - 1 + T_RP);
  endtask

  task automatic t_write_pre();
    int j;
    do_reset();
    step(ACT, 1, 1'b0, 30);
    wait_ok(1, 1, j);
    step(WR, 1, 1'b0, 0);
    wait_ok(2, 1, j);
    chk("R10 write recovery before precharge", j, BL - 1 + T_WR);
  endtask

  task automatic t_prea();
    int j;
    do_reset();
    step(ACT, 0, 1'b0, 40);
    wait_ok(0, 3, j);
    step(ACT, 3, 1'b0, 43);
    step(PRE, 0, 1'b1, 0);
    chk("R11 early all-bank precharge flagged", int'(illegal), 1);
    chk("R11 refused all-bank precharge keeps bank open", st(0), 2);
    wait_ok(2, 3, j);
    step(PRE, 2, 1'b1, 0);
    chk("R11 bank 0 closing", st(0), 3);
    chk("R11 bank 3 closing", st(3), 3);
    chk("R11 idle bank stays idle", st(1), 0);
    wait_ok(3, 0, j);
    chk("R11 all-bank precharge to idle", j, T_RP);
  endtask

  task automatic t_pre_single();
    int j;
    do_reset();
    step(ACT, 3, 1'b0, 50);
    wait_ok(2, 3, j);
    step(PRE, 3, 1'b0, 0);
    chk("R12 phase after precharge", st(3), 3);
    wait_ok(3, 3, j);
    chk("R12 precharge to idle cycles", j, T_RP);
  endtask

  task automatic t_illegal();
    do_reset();
    step(ACT, 1, 1'b0, 5);
    step(ACT, 1, 1'b0, 9);
    chk("R13 repeated activate flagged", int'(illegal), 1);
    chk("R13 row unchanged", rowof(1), 5);
    chk("R13 phase unchanged", st(1), 1);
    nop();
    chk("R13 flag lasts one cycle", int'(illegal), 0);
    step(RD, 2, 1'b0, 0);
    chk("R13 read to idle bank flagged", int'(illegal), 1);
    chk("R13 idle bank stays idle", st(2), 0);
    step(3'd6, 0, 1'b0, 0);
    chk("R1 unused code is a no-op", int'(illegal), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_act_row();
    t_rrd();
    t_rc();
    t_read_ap();
    t_write_ap();
    t_write_pre();
    t_prea();
    t_pre_single();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule